// File: doc/BRIEF.md
# Rename Alias Map with Snapshots

This block keeps, for every architectural register of an out-of-order core, a record of where the newest value of that register lives. The value is either in the committed register file, or in the reorder-buffer slot of the youngest in-flight instruction that writes the register. The reorder-buffer slot number doubles as the physical register number. Up to four micro-ops are renamed each cycle. Each lane presents two source register numbers and, optionally, a destination register together with the reorder-buffer slot the allocator gave it. The block answers every source lookup in the same cycle. Later lanes see the destinations of earlier lanes in the same group.

A retire port hands an entry back to the committed file once its producer commits, unless a younger writer has taken over the entry since. Two snapshot slots can capture the whole map, and a recovery port can either load one of those snapshots back or return every entry to the committed file at once. While a recovery request is present, the block raises a stall and drops the renames presented in that cycle. The free list, value storage and replay of renames between a snapshot and a branch are handled elsewhere.

Configuration (8 architectural registers, 32 reorder-buffer slots, 4 lanes, 2 snapshots) is held in the package `rename_alias_pkg`.

Top module: `rename_alias_map`

## Requirements
- R1: After a cycle with `rst_n` low at the clock edge, every register looks up as committed: the in-ROB flag is 0 and the slot field is 0.
- R2: With no same-group writer, a source lookup returns the current entry of that register in the same cycle: the in-ROB flag 1 with the slot of the latest writer, or the committed code (flag 0, slot 0).
- R3: A renamed destination (lane valid, destination valid, no stall) makes that register look up as in-ROB with the given slot from the next cycle on.
- R4: A source in lane i that names the destination of a valid earlier lane j < i of the same group returns flag 1 with lane j's slot. When several earlier lanes write it, the highest-numbered one wins, and the highest-numbered writer lane also sets the stored entry.
- R5: A retire whose register entry is in-ROB with exactly the retiring slot returns that entry to committed on the next cycle. A retire whose slot differs leaves the entry unchanged.
- R6: A rename and a retire of the same register in the same cycle leave the entry pointing to the new rename's slot.
- R7: A snapshot request stores, in snapshot `ckpt_sel`, the map as it stands after that cycle's renames and retires.
- R8: A retire also returns matching entries inside each stored snapshot to committed, except in the snapshot being overwritten that cycle.
- R9: A restore request raises `ren_stall` in the same cycle, drops that cycle's renames, and loads snapshot `rec_sel` into the map on the next cycle, with any same-cycle retire applied to it.
- R10: A reset-to-committed request raises `ren_stall` and, on the next cycle, leaves every map entry and every snapshot committed. It takes priority over a restore, a snapshot or a rename in the same cycle.
- R11: A lane whose valid bit or destination-valid bit is low neither writes the map nor feeds later lanes of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 4 | Per-lane micro-op valid |
| ren_dst_valid | input | 4 | Per-lane destination present |
| ren_dst | input | 12 | Per-lane destination register, 3 bits per lane, lane 0 in the low bits |
| ren_slot | input | 20 | Per-lane reorder-buffer slot, 5 bits per lane |
| ren_src_a | input | 12 | Per-lane first source register |
| ren_src_b | input | 12 | Per-lane second source register |
| src_a_rob | output | 4 | First source lives in the reorder buffer |
| src_a_slot | output | 20 | First source slot (0 when committed) |
| src_b_rob | output | 4 | Second source lives in the reorder buffer |
| src_b_slot | output | 20 | Second source slot (0 when committed) |
| ren_stall | output | 1 | Renames are dropped this cycle |
| ret_valid | input | 1 | A producer commits |
| ret_dst | input | 3 | Destination register of the committing producer |
| ret_slot | input | 5 | Slot of the committing producer |
| ckpt_take | input | 1 | Capture a snapshot |
| ckpt_sel | input | 1 | Snapshot slot to write |
| rec_restore | input | 1 | Load a snapshot into the map |
| rec_sel | input | 1 | Snapshot slot to load |
| rec_reset | input | 1 | Return every entry and snapshot to committed |

## Verification
Lookups and `ren_stall` are combinational, so they are due in the cycle the inputs are presented. Map, retire, snapshot and recovery updates take one register stage and show up in lookups one clock edge later. The bench drives inputs on the falling edge and samples outputs one time unit later. It advances its reference map and snapshots exactly once per rising edge, so the expected value of any check reflects everything applied up to the preceding edge.

// File: rtl/rename_alias_pkg.sv
// Shared configuration, types and the retire-scrub helper for the rename alias map.
// Assumes ARCH_REGS and ROB_SLOTS are powers of two.
package rename_alias_pkg;
    localparam int ARCH_REGS = 8;
    localparam int ROB_SLOTS = 32;
    localparam int REN_W     = 4;
    localparam int NUM_CKPT  = 2;

    localparam int ARCH_BITS = $clog2(ARCH_REGS);
    localparam int SLOT_BITS = $clog2(ROB_SLOTS);
    localparam int CKPT_BITS = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1;

    typedef logic [ARCH_BITS-1:0] arch_t;
    typedef logic [SLOT_BITS-1:0] slot_t;

    // One map entry: committed when in_rob is 0 (slot then held at 0).
    typedef struct packed {
        logic  in_rob;
        slot_t slot;
    } ent_t;

    typedef ent_t [ARCH_REGS-1:0] map_t;

    // Return the entry of register r to committed if it still names slot s.
    function automatic map_t scrub_retire(map_t m, logic v, arch_t r, slot_t s);
        map_t o;
        o = m;
        if (v && m[r].in_rob && (m[r].slot == s)) begin
            o[r] = '0;
        end
        return o;
    endfunction
endpackage

// File: rtl/alias_src_lookup.sv
// Resolves one source operand per lane against the current map, with
// forwarding from earlier lanes of the same rename group.
// Assumes lane order is program order (lane 0 oldest).
module alias_src_lookup
    import rename_alias_pkg::*;
(
    input  map_t             cur_map,
    input  logic [REN_W-1:0] lane_v,
    input  logic [REN_W-1:0] dst_v,
    input  arch_t            dst   [REN_W],
    input  slot_t            slot  [REN_W],
    input  arch_t            src   [REN_W],
    output ent_t             res   [REN_W]
);
    for (genvar g = 0; g < REN_W; g++) begin : g_lane
        ent_t hit;
        // Latest earlier writer in the group overrides the stored entry.
        always_comb begin
            hit = cur_map[src[g]];
            for (int j = 0; j < g; j++) begin
                if (lane_v[j] && dst_v[j] && (dst[j] == src[g])) begin
                    hit = '{in_rob: 1'b1, slot: slot[j]};
                end
            end
        end
        assign res[g] = hit;
    end
endmodule

// File: rtl/alias_next_state.sv
// Computes the next map from the current map, a restore source, one retire
// and the group of renames. Reset-to-committed overrides everything,
// restore replaces the base and drops renames, rename beats retire.
module alias_next_state
    import rename_alias_pkg::*;
(
    input  map_t             cur_map,
    input  map_t             restore_map,
    input  logic             rec_restore,
    input  logic             rec_reset,
    input  logic             ret_v,
    input  arch_t            ret_dst,
    input  slot_t            ret_slot,
    input  logic [REN_W-1:0] lane_v,
    input  logic [REN_W-1:0] dst_v,
    input  arch_t            dst   [REN_W],
    input  slot_t            slot  [REN_W],
    output map_t             next_map
);
    // Apply base selection, retire scrub, renames in lane order, then clear.
    always_comb begin
        map_t work;
        work = rec_restore ? restore_map : cur_map;
        work = scrub_retire(work, ret_v, ret_dst, ret_slot);
        if (!rec_restore) begin
            for (int i = 0; i < REN_W; i++) begin
                if (lane_v[i] && dst_v[i]) begin
                    work[dst[i]] = '{in_rob: 1'b1, slot: slot[i]};
                end
            end
        end
        if (rec_reset) begin
            work = '0;
        end
        next_map = work;
    end
endmodule

// File: rtl/alias_snapshot_bank.sv
// Holds NUM_CKPT copies of the map. A capture stores the post-update map;
// untouched copies have retiring entries returned to committed.
// Assumes NUM_CKPT is a power of two so every select value is a real slot.
module alias_snapshot_bank
    import rename_alias_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 take,
    input  logic [CKPT_BITS-1:0] take_sel,
    input  map_t                 next_map,
    input  logic                 ret_v,
    input  arch_t                ret_dst,
    input  slot_t                ret_slot,
    input  logic [CKPT_BITS-1:0] rd_sel,
    output map_t                 rd_map
);
    map_t snap_all [NUM_CKPT];

    for (genvar c = 0; c < NUM_CKPT; c++) begin : g_snap
        map_t snap_q;
        // Capture, clear or scrub this snapshot copy.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                snap_q <= '0;
            end else if (take && (take_sel == CKPT_BITS'(c))) begin
                snap_q <= next_map;
            end else begin
                snap_q <= scrub_retire(snap_q, ret_v, ret_dst, ret_slot);
            end
        end
        assign snap_all[c] = snap_q;
    end

    assign rd_map = snap_all[rd_sel];
endmodule

// File: rtl/rename_alias_map.sv
// Top of the rename alias map: per-architectural-register location of the
// newest value, group rename with in-group forwarding, retire release,
// snapshot capture and restore/reset recovery. Lookups are combinational;
// map updates land on the next rising edge.
module rename_alias_map
    import rename_alias_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [REN_W-1:0]           ren_valid,
    input  logic [REN_W-1:0]           ren_dst_valid,
    input  logic [REN_W*ARCH_BITS-1:0] ren_dst,
    input  logic [REN_W*SLOT_BITS-1:0] ren_slot,
    input  logic [REN_W*ARCH_BITS-1:0] ren_src_a,
    input  logic [REN_W*ARCH_BITS-1:0] ren_src_b,
    output logic [REN_W-1:0]           src_a_rob,
    output logic [REN_W*SLOT_BITS-1:0] src_a_slot,
    output logic [REN_W-1:0]           src_b_rob,
    output logic [REN_W*SLOT_BITS-1:0] src_b_slot,
    output logic                       ren_stall,
    input  logic                       ret_valid,
    input  logic [ARCH_BITS-1:0]       ret_dst,
    input  logic [SLOT_BITS-1:0]       ret_slot,
    input  logic                       ckpt_take,
    input  logic [CKPT_BITS-1:0]       ckpt_sel,
    input  logic                       rec_restore,
    input  logic [CKPT_BITS-1:0]       rec_sel,
    input  logic                       rec_reset
);
    arch_t dst_u   [REN_W];
    arch_t src_a_u [REN_W];
    arch_t src_b_u [REN_W];
    slot_t slot_u  [REN_W];
    ent_t  res_a   [REN_W];
    ent_t  res_b   [REN_W];

    map_t map_q;
    map_t next_map;
    map_t restore_map;

    for (genvar g = 0; g < REN_W; g++) begin : g_io
        assign dst_u[g]   = ren_dst  [g*ARCH_BITS +: ARCH_BITS];
        assign src_a_u[g] = ren_src_a[g*ARCH_BITS +: ARCH_BITS];
        assign src_b_u[g] = ren_src_b[g*ARCH_BITS +: ARCH_BITS];
        assign slot_u[g]  = ren_slot [g*SLOT_BITS +: SLOT_BITS];
        assign src_a_rob[g]                         = res_a[g].in_rob;
        assign src_a_slot[g*SLOT_BITS +: SLOT_BITS] = res_a[g].slot;
        assign src_b_rob[g]                         = res_b[g].in_rob;
        assign src_b_slot[g*SLOT_BITS +: SLOT_BITS] = res_b[g].slot;
    end

    assign ren_stall = rec_restore | rec_reset;

    alias_src_lookup u_look_a (
        .cur_map (map_q),
        .lane_v  (ren_valid),
        .dst_v   (ren_dst_valid),
        .dst     (dst_u),
        .slot    (slot_u),
        .src     (src_a_u),
        .res     (res_a)
    );

    alias_src_lookup u_look_b (
        .cur_map (map_q),
        .lane_v  (ren_valid),
        .dst_v   (ren_dst_valid),
        .dst     (dst_u),
        .slot    (slot_u),
        .src     (src_b_u),
        .res     (res_b)
    );

    alias_next_state u_next (
        .cur_map     (map_q),
        .restore_map (restore_map),
        .rec_restore (rec_restore),
        .rec_reset   (rec_reset),
        .ret_v       (ret_valid),
        .ret_dst     (ret_dst),
        .ret_slot    (ret_slot),
        .lane_v      (ren_valid),
        .dst_v       (ren_dst_valid),
        .dst         (dst_u),
        .slot        (slot_u),
        .next_map    (next_map)
    );

    alias_snapshot_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rec_reset),
        .take     (ckpt_take),
        .take_sel (ckpt_sel),
        .next_map (next_map),
        .ret_v    (ret_valid),
        .ret_dst  (ret_dst),
        .ret_slot (ret_slot),
        .rd_sel   (rec_sel),
        .rd_map   (restore_map)
    );

    // Live map register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= next_map;
        end
    end
endmodule

// File: rtl/rename_alias_map_chk.sv
// Property checker for rename_alias_map, attached by bind below.
module rename_alias_map_chk
    import rename_alias_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [REN_W-1:0]           ren_valid,
    input logic [REN_W-1:0]           ren_dst_valid,
    input logic [REN_W*ARCH_BITS-1:0] ren_dst,
    input logic [REN_W*SLOT_BITS-1:0] ren_slot,
    input logic [REN_W*ARCH_BITS-1:0] ren_src_a,
    input logic [REN_W-1:0]           src_a_rob,
    input logic [REN_W*SLOT_BITS-1:0] src_a_slot,
    input logic                       ren_stall,
    input logic                       ret_valid,
    input logic [ARCH_BITS-1:0]       ret_dst,
    input logic [SLOT_BITS-1:0]       ret_slot,
    input logic                       rec_restore,
    input logic                       rec_reset,
    input map_t                       map_q,
    input map_t                       restore_map
);
    localparam int LAST = REN_W - 1;

    arch_t last_dst_q;
    slot_t last_slot_q;
    arch_t ret_dst_q;
    logic  ren_hits_ret;

    // Remember the last lane's destination and the retire register for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_dst_q  <= '0;
            last_slot_q <= '0;
            ret_dst_q   <= '0;
        end else begin
            last_dst_q  <= ren_dst [LAST*ARCH_BITS +: ARCH_BITS];
            last_slot_q <= ren_slot[LAST*SLOT_BITS +: SLOT_BITS];
            ret_dst_q   <= ret_dst;
        end
    end

    // Any active lane renaming the retiring register this cycle.
    always_comb begin
        ren_hits_ret = 1'b0;
        for (int i = 0; i < REN_W; i++) begin
            if (ren_valid[i] && ren_dst_valid[i] &&
                (ren_dst[i*ARCH_BITS +: ARCH_BITS] == ret_dst)) begin
                ren_hits_ret = 1'b1;
            end
        end
    end

    // R1
    map_committed_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (map_q == '0));

    // R10
    recovery_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_reset |=> (map_q == '0));

    // R9
    restore_loads_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_restore && !rec_reset && !ret_valid) |=> (map_q == $past(restore_map)));

    // R3
    last_lane_rename_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[LAST] && ren_dst_valid[LAST] && !ren_stall)
        |=> (map_q[last_dst_q].in_rob && (map_q[last_dst_q].slot == last_slot_q)));

    // R5
    retire_releases_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && map_q[ret_dst].in_rob && (map_q[ret_dst].slot == ret_slot) &&
         !ren_hits_ret && !rec_restore && !rec_reset)
        |=> !map_q[ret_dst_q].in_rob);

    if (REN_W > 1) begin : g_fwd
        // R4
        group_forward_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid[0] && ren_dst_valid[0] &&
             (ren_src_a[2*ARCH_BITS-1:ARCH_BITS] == ren_dst[ARCH_BITS-1:0]))
            |-> (src_a_rob[1] && (src_a_slot[2*SLOT_BITS-1:SLOT_BITS] == ren_slot[SLOT_BITS-1:0])));
    end
endmodule

bind rename_alias_map rename_alias_map_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_valid     (ren_valid),
    .ren_dst_valid (ren_dst_valid),
    .ren_dst       (ren_dst),
    .ren_slot      (ren_slot),
    .ren_src_a     (ren_src_a),
    .src_a_rob     (src_a_rob),
    .src_a_slot    (src_a_slot),
    .ren_stall     (ren_stall),
    .ret_valid     (ret_valid),
    .ret_dst       (ret_dst),
    .ret_slot      (ret_slot),
    .rec_restore   (rec_restore),
    .rec_reset     (rec_reset),
    .map_q         (map_q),
    .restore_map   (restore_map)
);

// File: tb/rename_alias_map_tb.sv
// Self-checking bench: reference map and snapshots kept in bench arrays,
// directed corner cases then seeded random traffic.
module rename_alias_map_tb;
    import rename_alias_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RANDOM_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [REN_W-1:0]           ren_valid = '0, ren_dst_valid = '0;
    logic [REN_W*ARCH_BITS-1:0] ren_dst = '0, ren_src_a = '0, ren_src_b = '0;
    logic [REN_W*SLOT_BITS-1:0] ren_slot = '0;
    logic [REN_W-1:0]           src_a_rob, src_b_rob;
    logic [REN_W*SLOT_BITS-1:0] src_a_slot, src_b_slot;
    logic                       ren_stall;
    logic                       ret_valid = 1'b0;
    logic [ARCH_BITS-1:0]       ret_dst = '0;
    logic [SLOT_BITS-1:0]       ret_slot = '0;
    logic                       ckpt_take = 1'b0, rec_restore = 1'b0, rec_reset = 1'b0;
    logic [CKPT_BITS-1:0]       ckpt_sel = '0, rec_sel = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench stimulus for one cycle.
    bit s_v[REN_W], s_dv[REN_W];
    int s_dst[REN_W], s_slot[REN_W], s_sa[REN_W], s_sb[REN_W];
    bit s_ret, s_take, s_rest, s_rreset, s_rst;
    int s_rd, s_rs, s_tsel, s_rsel;

    // Reference state: 0 = committed, 256+slot = in ROB.
    int m_map[ARCH_REGS];
    int m_ck[NUM_CKPT][ARCH_REGS];

    rename_alias_map u_dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_dst_valid(ren_dst_valid),
        .ren_dst(ren_dst), .ren_slot(ren_slot), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .src_a_rob(src_a_rob), .src_a_slot(src_a_slot), .src_b_rob(src_b_rob),
        .src_b_slot(src_b_slot), .ren_stall(ren_stall), .ret_valid(ret_valid),
        .ret_dst(ret_dst), .ret_slot(ret_slot), .ckpt_take(ckpt_take), .ckpt_sel(ckpt_sel),
        .rec_restore(rec_restore), .rec_sel(rec_sel), .rec_reset(rec_reset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        for (int i = 0; i < REN_W; i++) begin
            s_v[i] = 0; s_dv[i] = 0; s_dst[i] = 0; s_slot[i] = 0; s_sa[i] = i; s_sb[i] = i + REN_W;
        end
        s_ret = 0; s_take = 0; s_rest = 0; s_rreset = 0; s_rst = 0;
        s_rd = 0; s_rs = 0; s_tsel = 0; s_rsel = 0;
    endtask

    task automatic set_lane(int l, int dst, int slot);
        s_v[l] = 1; s_dv[l] = 1; s_dst[l] = dst; s_slot[l] = slot;
    endtask

    function automatic int exp_lookup(int lane, int src);
        int e;
        e = m_map[src];
        for (int j = 0; j < lane; j++) begin
            if (s_v[j] && s_dv[j] && s_dst[j] == src) e = 256 + s_slot[j];
        end
        return e;
    endfunction

    task automatic model_edge();
        int n[ARCH_REGS];
        if (s_rst || s_rreset) begin
            for (int r = 0; r < ARCH_REGS; r++) begin
                m_map[r] = 0;
                for (int c = 0; c < NUM_CKPT; c++) m_ck[c][r] = 0;
            end
            return;
        end
        for (int r = 0; r < ARCH_REGS; r++) n[r] = s_rest ? m_ck[s_rsel][r] : m_map[r];
        if (s_ret && n[s_rd] == 256 + s_rs) n[s_rd] = 0;
        if (!s_rest) begin
            for (int i = 0; i < REN_W; i++) if (s_v[i] && s_dv[i]) n[s_dst[i]] = 256 + s_slot[i];
        end
        for (int c = 0; c < NUM_CKPT; c++) begin
            if (s_take && s_tsel == c) begin
                for (int r = 0; r < ARCH_REGS; r++) m_ck[c][r] = n[r];
            end else if (s_ret && m_ck[c][s_rd] == 256 + s_rs) begin
                m_ck[c][s_rd] = 0;
            end
        end
        for (int r = 0; r < ARCH_REGS; r++) m_map[r] = n[r];
    endtask

    // Drive on the falling edge, check 1 time unit later, advance the model for the next rising edge.
    task automatic step(string tag);
        @(negedge clk);
        rst_n = !s_rst;
        for (int i = 0; i < REN_W; i++) begin
            ren_valid[i] = s_v[i];
            ren_dst_valid[i] = s_dv[i];
            ren_dst[i*ARCH_BITS +: ARCH_BITS] = ARCH_BITS'(s_dst[i]);
            ren_slot[i*SLOT_BITS +: SLOT_BITS] = SLOT_BITS'(s_slot[i]);
            ren_src_a[i*ARCH_BITS +: ARCH_BITS] = ARCH_BITS'(s_sa[i]);
            ren_src_b[i*ARCH_BITS +: ARCH_BITS] = ARCH_BITS'(s_sb[i]);
        end
        ret_valid = s_ret; ret_dst = ARCH_BITS'(s_rd); ret_slot = SLOT_BITS'(s_rs);
        ckpt_take = s_take; ckpt_sel = CKPT_BITS'(s_tsel);
        rec_restore = s_rest; rec_sel = CKPT_BITS'(s_rsel); rec_reset = s_rreset;
        #1;
        if (!s_rst) begin
            check(ren_stall == (s_rest || s_rreset), "R9 stall", int'(ren_stall), int'(s_rest || s_rreset));
            if (!s_rest && !s_rreset) begin
                for (int i = 0; i < REN_W; i++) begin
                    int ea, eb, aa, ab;
                    ea = exp_lookup(i, s_sa[i]);
                    eb = exp_lookup(i, s_sb[i]);
                    aa = int'(src_a_rob[i]) * 256 + int'(src_a_slot[i*SLOT_BITS +: SLOT_BITS]);
                    ab = int'(src_b_rob[i]) * 256 + int'(src_b_slot[i*SLOT_BITS +: SLOT_BITS]);
                    check(aa == ea, tag, aa, ea);
                    check(ab == eb, tag, ab, eb);
                end
            end
        end
        model_edge();
    endtask

    // Look up all registers across lanes and sources with no renames.
    task automatic probe_all(string tag);
        idle();
        step(tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int r = 0; r < ARCH_REGS; r++) begin
            m_map[r] = 0;
            for (int c = 0; c < NUM_CKPT; c++) m_ck[c][r] = 0;
        end
        idle(); s_rst = 1;
        repeat (3) step("R1");
        probe_all("R1");                        // R1: all registers committed after reset

        idle(); set_lane(0, 2, 7); step("R3");  // R3: rename r2 -> slot 7
        probe_all("R3");                        // r2 now in ROB slot 7

        // R4: chained writers inside one group, highest earlier lane wins
        idle(); set_lane(0, 3, 5); s_sa[1] = 3; set_lane(2, 3, 6); s_sa[3] = 3; s_sb[3] = 2;
        s_dst[1] = 1; s_v[1] = 1; s_dv[1] = 0; s_sb[2] = 1;   // R11: lane 1 has no destination
        step("R4");
        probe_all("R11");                       // r3 holds slot 6, r1 still committed

        // R5: retire with stale slot leaves r3, then matching slot releases it
        idle(); s_ret = 1; s_rd = 3; s_rs = 5; step("R5");
        probe_all("R5");
        idle(); s_ret = 1; s_rd = 3; s_rs = 6; step("R5");
        probe_all("R5");

        // R6: retire and rename of r2 in the same cycle
        idle(); s_ret = 1; s_rd = 2; s_rs = 7; set_lane(1, 2, 10); step("R6");
        probe_all("R6");

        // R7, R9: snapshot includes same-cycle rename, then restore after a newer rename
        idle(); s_take = 1; s_tsel = 0; set_lane(0, 1, 12); step("R7");
        idle(); set_lane(0, 1, 13); step("R7");
        idle(); s_rest = 1; s_rsel = 0; set_lane(0, 4, 14); step("R9");   // rename dropped
        probe_all("R9");

        // R8: retire scrubs snapshot 1, restore shows r5 committed
        idle(); s_take = 1; s_tsel = 1; set_lane(0, 5, 20); step("R8");
        idle(); s_ret = 1; s_rd = 5; s_rs = 20; set_lane(0, 5, 21); step("R8");
        idle(); s_rest = 1; s_rsel = 1; step("R8");
        probe_all("R8");

        // R10: reset-to-committed beats restore and rename in the same cycle
        idle(); set_lane(0, 6, 22); set_lane(1, 7, 23); step("R10");
        idle(); s_rreset = 1; s_rest = 1; s_rsel = 0; set_lane(0, 0, 3); step("R10");
        probe_all("R10");
        idle(); s_rest = 1; s_rsel = 1; step("R10");                       // snapshots cleared too
        probe_all("R10");

        // R2: seeded random traffic
        for (int k = 0; k < RANDOM_CYCLES; k++) begin
            idle();
            for (int i = 0; i < REN_W; i++) begin
                s_v[i] = ($urandom_range(0, 3) != 0);
                s_dv[i] = ($urandom_range(0, 4) != 0);
                s_dst[i] = $urandom_range(0, ARCH_REGS - 1);
                s_slot[i] = $urandom_range(0, ROB_SLOTS - 1);
                s_sa[i] = $urandom_range(0, ARCH_REGS - 1);
                s_sb[i] = $urandom_range(0, ARCH_REGS - 1);
            end
            s_ret = $urandom_range(0, 1);
            s_rd = $urandom_range(0, ARCH_REGS - 1);
            if (m_map[s_rd] >= 256 && $urandom_range(0, 9) < 7) s_rs = m_map[s_rd] - 256;
            else s_rs = $urandom_range(0, ROB_SLOTS - 1);
            s_take = ($urandom_range(0, 99) < 8);
            s_tsel = $urandom_range(0, NUM_CKPT - 1);
            s_rest = ($urandom_range(0, 99) < 4);
            s_rsel = $urandom_range(0, NUM_CKPT - 1);
            s_rreset = ($urandom_range(0, 99) < 1);
            step("R2");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule